// File: doc/BRIEF.md
# Selectable-Order Burst Address Generator

This block produces the word address for a four-beat memory burst. A start address is captured on one of two active-low address strobes: one driven by the processor, one by the cache controller. The upper bits are held in a register for the whole burst. The low bits come from a small beat counter, and an active-low advance input steps that counter from beat to beat.

A strap input picks one of two beat orders. In interleaved order each beat address is the start value XOR the beat index. In linear order each beat address is the start value plus the beat index, wrapping within the group. The wrap never carries into the upper bits.

The processor strobe counts only while the first chip enable is active. When both strobes are recognised together, the processor strobe wins. A recognised strobe loads the address only when all three chip selects are active. In any cycle where a strobe is recognised, the advance input is ignored.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets addr_out to zero.
- R2: When proc_strb_n is low and cs1_n is low, cs2 is high and cs3_n is low at a rising edge, addr_out equals addr_in from the next cycle on, whatever adv_n is.
- R3: When ctrl_strb_n is low with all chip selects active, the address is loaded in the same way. If both strobes are low and cs1_n is low, exactly one load of addr_in happens.
- R4: proc_strb_n is ignored while cs1_n is high. With no other strobe, the cycle then behaves as an advance or a hold, depending on adv_n.
- R5: A recognised strobe while any chip select is inactive (cs1_n high, cs2 low or cs3_n high) leaves addr_out unchanged, and adv_n is ignored in that cycle.
- R6: With no strobe recognised, adv_n low at a rising edge steps the beat index by one. The new address appears in the next cycle.
- R7: With no strobe recognised, adv_n high holds addr_out unchanged.
- R8: With order_ilv high, the low two address bits are start XOR beat. For example, start 01 gives 01,00,11,10 and start 10 gives 10,11,00,01.
- R9: With order_ilv low, the low two address bits are (start + beat) mod 4. For example, start 01 gives 01,10,11,00.
- R10: After four steps the low bits return to the start value, and the upper address bits never change during a burst.
- R11: order_ilv high selects interleaved order and low selects linear order. The input is static within a burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| order_ilv | input | 1 | Order strap: 1 interleaved, 0 linear |
| proc_strb_n | input | 1 | Processor address strobe, active low |
| ctrl_strb_n | input | 1 | Controller address strobe, active low |
| cs1_n | input | 1 | Chip select 1, active low; also gates proc_strb_n |
| cs2 | input | 1 | Chip select 2, active high |
| cs3_n | input | 1 | Chip select 3, active low |
| adv_n | input | 1 | Advance to next beat, active low |
| addr_in | input | ADDR_W | Start address |
| addr_out | output | ADDR_W | Current burst word address |

## Verification
The bench builds the block with ADDR_W = 6 and CNT_W = 2, with the order taken from the strap. The narrow 4-bit upper field lets random loads hit every start value and every upper pattern many times over. This shows that a wrap from 11 to 00 in linear order never disturbs the upper bits. Directed bursts in both orders cover all four start values, and random phases mix strobe collisions, deselects and suspends.

// File: rtl/burst_pkg.sv
package burst_pkg;

   typedef enum logic [1:0] {
      ORD_STRAP       = 2'd0,
      ORD_INTERLEAVED = 2'd1,
      ORD_LINEAR      = 2'd2
   } order_sel_e;

   typedef struct packed {
      logic recognised;
      logic load;
   } strobe_dec_t;

endpackage

// File: rtl/burst_strobe_arb.sv
module burst_strobe_arb
   import burst_pkg::*;
(
   input  logic        proc_strb_n,
   input  logic        ctrl_strb_n,
   input  logic        cs1_n,
   input  logic        cs2,
   input  logic        cs3_n,
   output strobe_dec_t dec
);
   logic proc_seen;
   logic ctrl_seen;
   logic selected;

   always_comb begin
      proc_seen      = !proc_strb_n && !cs1_n;
      ctrl_seen      = !ctrl_strb_n && !proc_seen;
      selected       = !cs1_n && cs2 && !cs3_n;
      dec.recognised = proc_seen || ctrl_seen;
      dec.load       = dec.recognised && selected;
   end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             step,
   input  logic [CNT_W-1:0] start_in,
   output logic [CNT_W-1:0] start_q,
   output logic [CNT_W-1:0] beat_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         start_q <= '0;
         beat_q  <= '0;
      end else if (load) begin
         start_q <= start_in;
         beat_q  <= '0;
      end else if (step) begin
         beat_q  <= beat_q + CNT_W'(1);
      end
   end

   assert_load_clears_beat_R2: assert property (@(posedge clk) disable iff (rst)
      load |=> (beat_q == '0) && (start_q == $past(start_in)));

   assert_step_increments_R6: assert property (@(posedge clk) disable iff (rst)
      (step && !load) |=> beat_q == $past(beat_q) + CNT_W'(1));

   assert_idle_holds_R7: assert property (@(posedge clk) disable iff (rst)
      (!step && !load) |=> $stable(beat_q) && $stable(start_q));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_pkg::*;
#(
   parameter int         CNT_W = 2,
   parameter order_sel_e ORDER = ORD_STRAP
) (
   input  logic             order_ilv,
   input  logic [CNT_W-1:0] start,
   input  logic [CNT_W-1:0] beat,
   output logic [CNT_W-1:0] low
);
   logic [CNT_W-1:0] ilv_low;
   logic [CNT_W-1:0] lin_low;

   always_comb begin
      ilv_low = start ^ beat;
      lin_low = start + beat;
   end

   generate
      if (ORDER == ORD_INTERLEAVED) begin : g_ilv
         always_comb low = ilv_low;
      end else if (ORDER == ORD_LINEAR) begin : g_lin
         always_comb low = lin_low;
      end else begin : g_strap
         always_comb low = order_ilv ? ilv_low : lin_low;
      end
   endgenerate

   always_comb begin
      if (beat == '0)
         assert_beat0_is_start_R10: assert (low == start);
   end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_pkg::*;
#(
   parameter int         ADDR_W = 17,
   parameter int         CNT_W  = 2,
   parameter order_sel_e ORDER  = ORD_STRAP
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              order_ilv,
   input  logic              proc_strb_n,
   input  logic              ctrl_strb_n,
   input  logic              cs1_n,
   input  logic              cs2,
   input  logic              cs3_n,
   input  logic              adv_n,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out
);
   localparam int UP_W = ADDR_W - CNT_W;

   generate
      if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
         $error("burst_addr_gen: CNT_W out of range");
      end
      if (UP_W < 1) begin : g_bad_addr
         $error("burst_addr_gen: ADDR_W must exceed CNT_W");
      end
   endgenerate

   strobe_dec_t      dec;
   logic             step;
   logic [UP_W-1:0]  upper_q;
   logic [CNT_W-1:0] start_q;
   logic [CNT_W-1:0] beat_q;
   logic [CNT_W-1:0] low;

   burst_strobe_arb u_arb (
      .proc_strb_n (proc_strb_n),
      .ctrl_strb_n (ctrl_strb_n),
      .cs1_n       (cs1_n),
      .cs2         (cs2),
      .cs3_n       (cs3_n),
      .dec         (dec)
   );

   always_comb step = !dec.recognised && !adv_n;

   always_ff @(posedge clk) begin
      if (rst)
         upper_q <= '0;
      else if (dec.load)
         upper_q <= addr_in[ADDR_W-1:CNT_W];
   end

   burst_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .load     (dec.load),
      .step     (step),
      .start_in (addr_in[CNT_W-1:0]),
      .start_q  (start_q),
      .beat_q   (beat_q)
   );

   burst_order_map #(.CNT_W(CNT_W), .ORDER(ORDER)) u_map (
      .order_ilv (order_ilv),
      .start     (start_q),
      .beat      (beat_q),
      .low       (low)
   );

   always_comb addr_out = {upper_q, low};

   assert_load_captures_R2: assert property (@(posedge clk) disable iff (rst)
      dec.load |=> addr_out == $past(addr_in));

   assert_deselect_holds_R5: assert property (@(posedge clk) disable iff (rst)
      (dec.recognised && !dec.load) |=> $stable(addr_out));

   assert_suspend_holds_R7: assert property (@(posedge clk) disable iff (rst)
      (!dec.recognised && adv_n) |=> $stable(addr_out));

   assert_upper_fixed_R10: assert property (@(posedge clk) disable iff (rst)
      !dec.load |=> $stable(upper_q));
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
   localparam int AW = 6;
   localparam int CW = 2;

   logic          clk = 1'b0;
   logic          rst;
   logic          order_ilv;
   logic          proc_strb_n, ctrl_strb_n, cs1_n, cs2, cs3_n, adv_n;
   logic [AW-1:0] addr_in;
   logic [AW-1:0] addr_out;

   int n_chk  = 0;
   int n_fail = 0;

   logic [AW-CW-1:0] m_up;
   logic [CW-1:0]    m_start;
   logic [CW-1:0]    m_beat;

   always #2 clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
      .clk (clk), .rst (rst), .order_ilv (order_ilv),
      .proc_strb_n (proc_strb_n), .ctrl_strb_n (ctrl_strb_n),
      .cs1_n (cs1_n), .cs2 (cs2), .cs3_n (cs3_n),
      .adv_n (adv_n), .addr_in (addr_in), .addr_out (addr_out)
   );

   function automatic logic [AW-1:0] expected_addr();
      logic [CW-1:0] lo;
      if (order_ilv) lo = m_start ^ m_beat;
      else           lo = CW'((int'(m_start) + int'(m_beat)) % 4);
      return {m_up, lo};
   endfunction

   task automatic check(input string req, input logic [AW-1:0] exp);
      n_chk++;
      if (addr_out !== exp) begin
         n_fail++;
         $display("FAIL %s: addr_out=%h expected %h", req, addr_out, exp);
      end
   endtask

   task automatic cyc(input logic p, input logic c, input logic e1, input logic e2,
                      input logic e3, input logic a, input logic [AW-1:0] ad);
      logic rec, sel;
      proc_strb_n = p; ctrl_strb_n = c; cs1_n = e1; cs2 = e2; cs3_n = e3;
      adv_n = a; addr_in = ad;
      @(posedge clk);
      rec = (!p && !e1) || !c;
      sel = !e1 && e2 && !e3;
      if (rst) begin
         m_up = '0; m_start = '0; m_beat = '0;
      end else if (rec) begin
         if (sel) begin
            m_up = ad[AW-1:CW]; m_start = ad[CW-1:0]; m_beat = '0;
         end
      end else if (!a) begin
         m_beat = m_beat + CW'(1);
      end
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      finish_run();
   end

   initial begin
      logic [AW-1:0] st;
      logic [AW-1:0] ra;
      rst = 1'b1; order_ilv = 1'b1;
      m_up = '0; m_start = '0; m_beat = '0;
      @(negedge clk);
      repeat (3) cyc(1, 1, 0, 1, 0, 1, '1);
      check("R1 reset", '0);
      rst = 1'b0;

      for (int m = 1; m >= 0; m--) begin
         for (int s = 0; s < 4; s++) begin
            cyc(0, 1, 0, 1, 0, 0, AW'(6'h28 + s));
            order_ilv = logic'(m);
            check("R2 load ignores advance", AW'(6'h28 + s));
            for (int b = 1; b <= 4; b++) begin
               cyc(1, 1, 0, 1, 0, 0, '0);
               if (b == 4) check("R10 wrap to start", AW'(6'h28 + s));
               else if (m == 1) check("R8 R11 interleaved beat", expected_addr());
               else check("R9 R11 linear beat", expected_addr());
            end
            cyc(1, 1, 0, 1, 0, 1, '0);
            check("R7 suspend", expected_addr());
         end
      end

      cyc(0, 1, 0, 1, 0, 0, 6'h3F);
      order_ilv = 1'b0;
      cyc(1, 1, 0, 1, 0, 0, '0);
      check("R10 linear wrap keeps upper", 6'h3C);
      cyc(1, 1, 0, 1, 0, 0, '0);
      check("R9 linear step", 6'h3D);

      cyc(1, 0, 0, 1, 0, 0, 6'h16);
      check("R3 controller load", 6'h16);
      cyc(0, 0, 0, 1, 0, 0, 6'h09);
      check("R3 both strobes load once", 6'h09);
      cyc(0, 1, 1, 1, 0, 0, 6'h33);
      check("R4 processor strobe ignored, advanced", 6'h0A);
      cyc(0, 1, 1, 1, 0, 1, 6'h33);
      check("R4 processor strobe ignored, held", 6'h0A);
      cyc(1, 0, 0, 0, 0, 0, 6'h21);
      check("R5 cs2 low no load no step", 6'h0A);
      cyc(1, 0, 0, 1, 1, 0, 6'h21);
      check("R5 cs3_n high no load no step", 6'h0A);
      cyc(0, 0, 1, 1, 0, 0, 6'h21);
      check("R5 cs1_n high controller deselect", 6'h0A);
      cyc(1, 1, 0, 1, 0, 0, '0);
      check("R6 advance", 6'h0B);

      rst = 1'b1;
      cyc(1, 1, 0, 1, 0, 0, '0);
      check("R1 mid-run reset", '0);
      rst = 1'b0;

      void'($urandom(32'h5EED));
      for (int ph = 0; ph < 4; ph++) begin
         ra = AW'($urandom);
         cyc(0, 1, 0, 1, 0, 1, ra);
         order_ilv = logic'(ph % 2);
         check("R2 phase load", ra);
         for (int i = 0; i < 1500; i++) begin
            st = AW'($urandom);
            cyc(($urandom % 5) != 0, ($urandom % 5) != 0, ($urandom % 7) == 0,
                ($urandom % 7) != 0, ($urandom % 7) == 0, ($urandom % 5) < 2, st);
            check("R6 random mix", expected_addr());
         end
      end
      finish_run();
   end
endmodule